// File: doc/BRIEF.md
# SD Command Issue and Status Unit

This unit sits between a register interface and a serial SD command-line engine. Software writes a 32-bit argument and then a packed 16-bit command word. The unit decodes the word into an index, a response class and data-phase flags. It then sends one issue pulse to the engine and waits for the response or for a timeout.

The returned response is stored in four 32-bit response words, shaped by the response class. Events collect in a sticky, write-one-to-clear status register. An interrupt line is raised for any status bit that is not masked.

For multi-block transfers the unit can issue the stop command (index 12, zero argument, R1-with-busy class) by itself once the data path reports that the transfer has ended. Software can also cut a running data phase short at any moment.

Top module: `sdc_cmd_unit`

Register addresses: 0 argument, 1 command word, 2 stop control, 3 status, 4 mask, 5 to 8 response words 0 to 3.

## Requirements
- R1: After reset, status reads 0, mask reads 0xFF, and busy, irq, eng_start, dat_active and stop_now are all 0.
- R2: When the command word is written while the unit is idle, eng_start pulses high for exactly one cycle after that write. The command word is decoded as follows: eng_index = word[5:0], eng_app = word[6], eng_rtype = word[10:8], data phase = word[11], read = word[12], multi-block = word[13], eng_secure = word[14]. eng_arg carries the argument written before the command word.
- R3: A response for class 6 (long) is stored as rsp_raw[127:0]: word0 = bits 31:0 and word3 = bits 127:96. The leading 8 bits (135:128) are dropped.
- R4: A response for any other class stores rsp_raw[39:8] in word0 and zero in words 1 to 3.
- R5: Status bits: 0 command done, 1 timeout, 2 CRC fail, 3 card insert, 4 card remove, 5 illegal access, 6 data end, 7 auto-stop done. The bits are sticky. Writing 1 to a bit at address 3 clears it. If a new event arrives in the same cycle as the clear, the event wins.
- R6: irq is high exactly when some status bit is 1 and its mask bit is 0.
- R7: If no response arrives within TIMEOUT_CYC cycles of issue, status bits 0 and 1 are set and busy returns to 0.
- R8: A response that arrives with rsp_crc_err set sets status bit 2. The unit then returns to idle, and no data phase starts even if word[11] was set.
- R9: A command word written while busy is ignored: no eng_start pulse and eng_index is unchanged. Status bit 5 is set.
- R10: After a clean response to a command with the data flag set, dat_active is 1 and dat_read follows word[12]. A data_done pulse ends the data phase and sets status bit 6.
- R11: If stop control bit 8 is set and the command was multi-block, data_done makes eng_start pulse with index 12, argument 0 and class 5. Its response sets status bit 7 and is not stored in the response words. With bit 8 clear, no stop command is issued.
- R12: Writing stop control with bit 0 set during a data phase pulses stop_now for one cycle, ends the data phase and sets status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | WORD_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | WORD_W | Register read data (combinational) |
| eng_start | output | 1 | One-cycle issue pulse to the command-line engine |
| eng_index | output | 6 | Command index being issued |
| eng_arg | output | WORD_W | Command argument being issued |
| eng_rtype | output | 3 | Response class being issued |
| eng_app | output | 1 | Application-specific command flag |
| eng_secure | output | 1 | Security command flag |
| rsp_valid | input | 1 | Response returned by the engine |
| rsp_crc_err | input | 1 | Returned response failed its CRC |
| rsp_raw | input | 4*WORD_W+8 | Raw response bits |
| dat_active | output | 1 | Data phase in progress |
| dat_read | output | 1 | Direction of the data phase (1 = read) |
| data_done | input | 1 | Data path reports end of transfer |
| stop_now | output | 1 | One-cycle forced stop of the data path |
| card_insert | input | 1 | Card insertion event |
| card_remove | input | 1 | Card removal event |
| busy | output | 1 | A command or data phase is in progress |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with TIMEOUT_CYC = 16 in place of the default 1024. This brings the timeout path and the auto-stop timeout within a few dozen cycles, so both can be checked directly. Word width and address width stay at their defaults, so the register map and the field positions are the ones listed in the requirements.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;

   typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DATA, SQ_STOP} seq_state_e;

   typedef struct packed {
      logic       secure;
      logic       multi;
      logic       read;
      logic       data;
      logic [2:0] rtype;
      logic       app;
      logic [5:0] index;
   } cmd_fields_t;

   localparam int ST_W      = 8;
   localparam int ST_DONE   = 0;
   localparam int ST_TMO    = 1;
   localparam int ST_CRC    = 2;
   localparam int ST_INS    = 3;
   localparam int ST_REM    = 4;
   localparam int ST_ILL    = 5;
   localparam int ST_DEND   = 6;
   localparam int ST_ASTOP  = 7;

   localparam logic [2:0] RT_LONG = 3'd6;
   localparam logic [2:0] RT_BUSY = 3'd5;
   localparam logic [5:0] STOP_IDX = 6'd12;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
   import sdc_cmd_pkg::*;
(
   input  logic [15:0] word,
   output cmd_fields_t fields
);
   logic unused_w;
   assign unused_w = word[15] ^ word[7];

   always_comb begin
      fields.index  = word[5:0];
      fields.app    = word[6];
      fields.rtype  = word[10:8];
      fields.data   = word[11];
      fields.read   = word[12];
      fields.multi  = word[13];
      fields.secure = word[14];
   end
endmodule

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
   import sdc_cmd_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  cmd_fields_t       fields,
   input  logic [WORD_W-1:0] arg,
   input  logic              stop_arm,
   input  logic              abort_req,
   input  logic              rsp_valid,
   input  logic              rsp_crc_err,
   input  logic              data_done,
   output logic              eng_start,
   output logic [5:0]        eng_index,
   output logic [WORD_W-1:0] eng_arg,
   output logic [2:0]        eng_rtype,
   output logic              eng_app,
   output logic              eng_secure,
   output logic              busy,
   output logic              dat_active,
   output logic              dat_read,
   output logic              stop_now,
   output logic              capture,
   output logic              cur_long,
   output logic [ST_W-1:0]   ev
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

   seq_state_e        state;
   cmd_fields_t       cur;
   logic [WORD_W-1:0] arg_l;
   logic [CNT_W-1:0]  cnt;
   logic              tmo;

   assign tmo = (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cur       <= '0;
         arg_l     <= '0;
         cnt       <= '0;
         eng_start <= 1'b0;
         stop_now  <= 1'b0;
      end else begin
         eng_start <= 1'b0;
         stop_now  <= 1'b0;
         case (state)
            SQ_IDLE: if (launch) begin
               state     <= SQ_WAIT;
               cur       <= fields;
               arg_l     <= arg;
               cnt       <= '0;
               eng_start <= 1'b1;
            end
            SQ_WAIT: begin
               if (rsp_valid)
                  state <= (cur.data && !rsp_crc_err) ? SQ_DATA : SQ_IDLE;
               else if (tmo)
                  state <= SQ_IDLE;
               else
                  cnt <= cnt + 1'b1;
            end
            SQ_DATA: begin
               if (abort_req) begin
                  state    <= SQ_IDLE;
                  stop_now <= 1'b1;
               end else if (data_done) begin
                  if (cur.multi && stop_arm) begin
                     state     <= SQ_STOP;
                     cnt       <= '0;
                     eng_start <= 1'b1;
                  end else begin
                     state <= SQ_IDLE;
                  end
               end
            end
            SQ_STOP: begin
               if (rsp_valid || tmo) state <= SQ_IDLE;
               else                  cnt   <= cnt + 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      eng_index  = (state == SQ_STOP) ? STOP_IDX : cur.index;
      eng_arg    = (state == SQ_STOP) ? '0 : arg_l;
      eng_rtype  = (state == SQ_STOP) ? RT_BUSY : cur.rtype;
      eng_app    = cur.app;
      eng_secure = cur.secure;
      busy       = (state != SQ_IDLE);
      dat_active = (state == SQ_DATA);
      dat_read   = cur.read;
      capture    = (state == SQ_WAIT) && rsp_valid;
      cur_long   = (cur.rtype == RT_LONG);
      ev           = '0;
      ev[ST_DONE]  = (state == SQ_WAIT) && (rsp_valid || tmo);
      ev[ST_TMO]   = ((state == SQ_WAIT) || (state == SQ_STOP)) && !rsp_valid && tmo;
      ev[ST_CRC]   = (state == SQ_WAIT) && rsp_valid && rsp_crc_err;
      ev[ST_DEND]  = (state == SQ_DATA) && (abort_req || data_done);
      ev[ST_ASTOP] = (state == SQ_STOP) && (rsp_valid || tmo);
   end
endmodule

// File: rtl/sdc_cmd_resp.sv
module sdc_cmd_resp #(
   parameter int WORD_W = 32,
   parameter int NWORDS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       capture,
   input  logic                       is_long,
   input  logic [NWORDS*WORD_W+7:0]   raw,
   output logic [NWORDS*WORD_W-1:0]   words
);
   localparam int BODY_W = NWORDS * WORD_W;

   logic unused_hdr;
   assign unused_hdr = ^raw[BODY_W+7:BODY_W];

   for (genvar i = 0; i < NWORDS; i++) begin : g_word
      logic [WORD_W-1:0] short_val;
      if (i == 0) begin : g_first
         assign short_val = raw[8 +: WORD_W];
      end else begin : g_rest
         assign short_val = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[i*WORD_W +: WORD_W] <= '0;
         else if (capture)
            words[i*WORD_W +: WORD_W] <= is_long ? raw[i*WORD_W +: WORD_W] : short_val;
      end
   end
endmodule

// File: rtl/sdc_cmd_status.sv
module sdc_cmd_status #(
   parameter int          NBITS      = 8,
   parameter logic [7:0]  MASK_RESET = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] set_vec,
   input  logic [NBITS-1:0] clr_vec,
   input  logic             mask_we,
   input  logic [NBITS-1:0] mask_in,
   output logic [NBITS-1:0] status,
   output logic [NBITS-1:0] mask,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= NBITS'(MASK_RESET);
         irq    <= 1'b0;
      end else begin
         status <= (status & ~clr_vec) | set_vec;
         if (mask_we) mask <= mask_in;
         irq <= |(((status & ~clr_vec) | set_vec) & ~(mask_we ? mask_in : mask));
      end
   end
endmodule

// File: rtl/sdc_cmd_unit.sv
module sdc_cmd_unit
   import sdc_cmd_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [WORD_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [WORD_W-1:0]     rd_data,
   output logic                  eng_start,
   output logic [5:0]            eng_index,
   output logic [WORD_W-1:0]     eng_arg,
   output logic [2:0]            eng_rtype,
   output logic                  eng_app,
   output logic                  eng_secure,
   input  logic                  rsp_valid,
   input  logic                  rsp_crc_err,
   input  logic [4*WORD_W+7:0]   rsp_raw,
   output logic                  dat_active,
   output logic                  dat_read,
   input  logic                  data_done,
   output logic                  stop_now,
   input  logic                  card_insert,
   input  logic                  card_remove,
   output logic                  busy,
   output logic                  irq
);
   localparam int NWORDS = 4;
   localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_STOP = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(4);
   localparam int RSP_BASE = 5;

   if (WORD_W < 32) begin : g_bad_word
      $error("WORD_W must be at least 32");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("TIMEOUT_CYC must be at least 2");
   end

   logic [WORD_W-1:0]        arg_q;
   logic [15:0]              cmd_q;
   logic                     stop_arm;
   cmd_fields_t              fields;
   logic                     cmd_wr, launch, abort_req, capture, cur_long;
   logic [ST_W-1:0]          ev, set_vec, clr_vec, status, mask;
   logic [NWORDS*WORD_W-1:0] words;

   assign cmd_wr    = wr_en && (wr_addr == A_CMD);
   assign launch    = cmd_wr && !busy;
   assign abort_req = wr_en && (wr_addr == A_STOP) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arg_q    <= '0;
         cmd_q    <= '0;
         stop_arm <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_ARG)  arg_q    <= wr_data;
         if (launch)            cmd_q    <= wr_data[15:0];
         if (wr_addr == A_STOP) stop_arm <= wr_data[8];
      end
   end

   sdc_cmd_decode u_dec (.word(wr_data[15:0]), .fields(fields));

   sdc_cmd_seq #(.WORD_W(WORD_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .fields(fields), .arg(arg_q),
      .stop_arm(stop_arm), .abort_req(abort_req), .rsp_valid(rsp_valid),
      .rsp_crc_err(rsp_crc_err), .data_done(data_done), .eng_start(eng_start),
      .eng_index(eng_index), .eng_arg(eng_arg), .eng_rtype(eng_rtype),
      .eng_app(eng_app), .eng_secure(eng_secure), .busy(busy),
      .dat_active(dat_active), .dat_read(dat_read), .stop_now(stop_now),
      .capture(capture), .cur_long(cur_long), .ev(ev));

   sdc_cmd_resp #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_resp (
      .clk(clk), .rst_n(rst_n), .capture(capture), .is_long(cur_long),
      .raw(rsp_raw), .words(words));

   always_comb begin
      set_vec         = ev;
      set_vec[ST_INS] = card_insert;
      set_vec[ST_REM] = card_remove;
      set_vec[ST_ILL] = cmd_wr && busy;
      clr_vec = (wr_en && (wr_addr == A_STAT)) ? wr_data[ST_W-1:0] : '0;
   end

   sdc_cmd_status #(.NBITS(ST_W), .MASK_RESET(8'hFF)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
      .mask_we(wr_en && (wr_addr == A_MASK)), .mask_in(wr_data[ST_W-1:0]),
      .status(status), .mask(mask), .irq(irq));

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_ARG:  rd_data = arg_q;
         A_CMD:  rd_data = WORD_W'(cmd_q);
         A_STOP: rd_data = WORD_W'({stop_arm, 8'h00});
         A_STAT: rd_data = WORD_W'(status);
         A_MASK: rd_data = WORD_W'(mask);
         default: begin
            for (int i = 0; i < NWORDS; i++)
               if (rd_addr == ADDR_W'(RSP_BASE + i))
                  rd_data = words[i*WORD_W +: WORD_W];
         end
      endcase
   end
endmodule

// File: rtl/sdc_cmd_unit_chk.sv
module sdc_cmd_unit_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [31:0]       wr_data,
   input logic              eng_start,
   input logic              busy,
   input logic              rsp_valid,
   input logic              dat_active,
   input logic              stop_now,
   input logic              card_insert,
   input logic [7:0]        status
);
   // R2
   issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   // R9
   illegal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(1) && busy) |=> (!eng_start && status[5]));

   // R5
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_insert |=> status[3]);

   // R12
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(2) && wr_data[0] && dat_active) |=> (stop_now && !dat_active));

   // R10
   data_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_active) |-> $past(rsp_valid));
endmodule

bind sdc_cmd_unit sdc_cmd_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data[31:0]), .eng_start(eng_start), .busy(busy),
   .rsp_valid(rsp_valid), .dat_active(dat_active), .stop_now(stop_now),
   .card_insert(card_insert), .status(status));

// File: tb/sdc_cmd_unit_test.sv
module sdc_cmd_unit_test;
   localparam int TMO = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_addr = '0;
   logic [31:0]  wr_data = '0;
   logic [3:0]   rd_addr = '0;
   logic [31:0]  rd_data;
   logic         eng_start, eng_app, eng_secure;
   logic [5:0]   eng_index;
   logic [31:0]  eng_arg;
   logic [2:0]   eng_rtype;
   logic         rsp_valid = 1'b0, rsp_crc_err = 1'b0;
   logic [135:0] rsp_raw = '0;
   logic         dat_active, dat_read, stop_now, busy, irq;
   logic         data_done = 1'b0, card_insert = 1'b0, card_remove = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sdc_cmd_unit #(.WORD_W(32), .ADDR_W(4), .TIMEOUT_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .eng_start(eng_start),
      .eng_index(eng_index), .eng_arg(eng_arg), .eng_rtype(eng_rtype),
      .eng_app(eng_app), .eng_secure(eng_secure), .rsp_valid(rsp_valid),
      .rsp_crc_err(rsp_crc_err), .rsp_raw(rsp_raw), .dat_active(dat_active),
      .dat_read(dat_read), .data_done(data_done), .stop_now(stop_now),
      .card_insert(card_insert), .card_remove(card_remove), .busy(busy), .irq(irq));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic resp(logic [135:0] raw, logic crc);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_raw = raw; rsp_crc_err = crc;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_crc_err = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk);
      data_done = 1'b1;
      @(negedge clk);
      data_done = 1'b0;
   endtask

   task automatic clear_all();
      wr(4'd3, 32'hFF);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'd3, v); chk("R1 status", v, 0);
      rd(4'd4, v); chk("R1 mask", v, 32'hFF);
      chk("R1 outputs", {busy, irq, eng_start, dat_active, stop_now}, 0);
   endtask

   task automatic t_issue_short();
      logic [31:0] v;
      wr(4'd0, 32'h1234_5678);
      wr(4'd1, 32'h4451);
      chk("R2 start", eng_start, 1);
      chk("R2 index", eng_index, 17);
      chk("R2 rtype", eng_rtype, 4);
      chk("R2 app/secure", {eng_app, eng_secure}, 2'b11);
      chk("R2 arg", eng_arg, 32'h1234_5678);
      @(negedge clk);
      chk("R2 single pulse", eng_start, 0);
      resp({96'h0, 32'hCAFE_F00D, 8'h01}, 1'b0);
      rd(4'd5, v); chk("R4 word0", v, 32'hCAFE_F00D);
      rd(4'd8, v); chk("R4 word3", v, 0);
      rd(4'd3, v); chk("R5 done bit", v, 32'h01);
      chk("R4 idle", busy, 0);
      clear_all();
   endtask

   task automatic t_long();
      logic [31:0] v;
      wr(4'd1, 32'h0602);
      resp({8'h3F, 32'h0123_4567, 32'h89AB_CDEF, 32'h1111_2222, 32'h3333_4444}, 1'b0);
      rd(4'd5, v); chk("R3 word0", v, 32'h3333_4444);
      rd(4'd6, v); chk("R3 word1", v, 32'h1111_2222);
      rd(4'd8, v); chk("R3 word3", v, 32'h0123_4567);
      clear_all();
   endtask

   task automatic t_irq();
      logic [31:0] v;
      @(negedge clk); card_remove = 1'b1;
      @(negedge clk); card_remove = 1'b0;
      rd(4'd3, v); chk("R5 remove bit", v, 32'h10);
      chk("R6 masked", irq, 0);
      wr(4'd4, 32'hEF);
      chk("R6 unmasked", irq, 1);
      wr(4'd3, 32'h10);
      chk("R6 after clear", irq, 0);
      wr(4'd4, 32'hFF);
   endtask

   task automatic t_clear_wins();
      logic [31:0] v;
      @(negedge clk); card_insert = 1'b1;
      @(negedge clk); card_insert = 1'b0;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h08; card_insert = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; card_insert = 1'b0;
      rd(4'd3, v); chk("R5 event wins", v, 32'h08);
      wr(4'd3, 32'h08);
      rd(4'd3, v); chk("R5 clear", v, 0);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      wr(4'd1, 32'h0401);
      repeat (TMO + 3) @(negedge clk);
      rd(4'd3, v); chk("R7 timeout bits", v, 32'h03);
      chk("R7 idle", busy, 0);
      clear_all();
   endtask

   task automatic t_crc();
      logic [31:0] v;
      wr(4'd1, 32'h0C05);
      resp('0, 1'b1);
      rd(4'd3, v); chk("R8 crc bit", v, 32'h05);
      chk("R8 no data phase", {busy, dat_active}, 0);
      clear_all();
   endtask

   task automatic t_illegal();
      logic [31:0] v;
      wr(4'd1, 32'h0407);
      wr(4'd1, 32'h0409);
      chk("R9 no start", eng_start, 0);
      chk("R9 index kept", eng_index, 7);
      rd(4'd3, v); chk("R9 illegal bit", v, 32'h20);
      resp('0, 1'b0);
      clear_all();
   endtask

   task automatic t_autostop();
      logic [31:0] v;
      wr(4'd2, 32'h100);
      wr(4'd0, 32'hAAAA_5555);
      wr(4'd1, 32'h3C12);
      resp({96'h0, 32'h0000_0900, 8'h00}, 1'b0);
      chk("R10 data phase", {dat_active, dat_read}, 2'b11);
      pulse_done();
      chk("R11 stop start", eng_start, 1);
      chk("R11 stop fields", {eng_index, eng_rtype}, {6'd12, 3'd5});
      chk("R11 stop arg", eng_arg, 0);
      resp({96'h0, 32'hDEAD_BEEF, 8'h00}, 1'b0);
      rd(4'd3, v); chk("R11 status", v, 32'hC1);
      rd(4'd5, v); chk("R11 not stored", v, 32'h0000_0900);
      chk("R11 idle", busy, 0);
      clear_all();
   endtask

   task automatic t_no_autostop();
      logic [31:0] v;
      wr(4'd2, 32'h000);
      wr(4'd1, 32'h2C12);
      resp('0, 1'b0);
      chk("R10 write dir", {dat_active, dat_read}, 2'b10);
      pulse_done();
      chk("R11 unarmed no start", eng_start, 0);
      chk("R11 unarmed idle", busy, 0);
      rd(4'd3, v); chk("R10 data end", v, 32'h41);
      clear_all();
   endtask

   task automatic t_abort();
      logic [31:0] v;
      wr(4'd1, 32'h1912);
      resp('0, 1'b0);
      wr(4'd2, 32'h001);
      chk("R12 stop pulse", stop_now, 1);
      chk("R12 idle", {busy, dat_active}, 0);
      @(negedge clk);
      chk("R12 pulse ends", stop_now, 0);
      rd(4'd3, v); chk("R12 data end", v, 32'h41);
      clear_all();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_issue_short();
      t_long();
      t_irq();
      t_clear_wins();
      t_timeout();
      t_crc();
      t_illegal();
      t_autostop();
      t_no_autostop();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule